// File: doc/BRIEF.md
# Binary Search Tree Sorter

This block keeps a growing set of integer items in a binary search tree held in its own node memory, and on command streams every stored item out in ascending order. Items arrive on a valid/ready input stream. Each accepted item is walked down from the root, one tree level per clock cycle, and is linked in as a new leaf. Nodes that are already in place are never moved or rebuilt. A new portion of items therefore costs only its own insertion walks, and the next readout returns the merged, sorted set.

Each node holds a value, a left-child pointer and a right-child pointer. Pointer value 0 is null, and nodes are allocated from address 1 upward, so the first item becomes the root at address 1. The readout is a recursive in-order walk. It is unrolled by an explicit return stack whose frames hold a node address and a return code that tells whether the call came from the left branch or the right branch. Items equal to a stored value go to the right subtree, so duplicates are kept in arrival order. If the walk would need more frames than the stack holds, the walk ends and a sticky error flag is raised.

Top module: `bst_sorter`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `out_last`, `busy` and `stk_err` are 0.
- R2: A readout emits every accepted item exactly once, in nondecreasing order, one item per `out_valid` cycle.
- R3: An item equal to a stored value goes to the right subtree, so duplicates are kept and all copies are emitted.
- R4: `out_last` is 1 together with `out_valid` on the final item of a complete readout, and on no other cycle.
- R5: While an insertion walk or a readout is in progress, `busy` is 1 and `in_ready` is 0, so input items wait.
- R6: `start_rd` has no effect while the tree is empty: no item is emitted and `busy` stays 0.
- R7: Items from a later portion are added to the existing tree, and the next readout returns all portions merged in order.
- R8: Once 2^AW-1 nodes are stored, `in_ready` stays 0 and further input items are not stored.
- R9: If a readout needs more than 2^SW stack frames, the readout ends after the item being emitted in that cycle, `out_last` is never raised for it, and `stk_err` is set and stays 1 until reset.
- R10: In the idle state, `start_rd` takes priority over input: `in_ready` is 0 in any cycle where `start_rd` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item is present |
| in_data | input | DW | Input item value (unsigned) |
| in_ready | output | 1 | Block accepts the input item this cycle |
| start_rd | input | 1 | Request a full ascending readout |
| out_valid | output | 1 | Output item is present |
| out_data | output | DW | Output item value |
| out_last | output | 1 | Final item of a complete readout |
| busy | output | 1 | Insertion walk or readout in progress |
| stk_err | output | 1 | Sticky return-stack overflow flag |

## Verification
The bench builds the block with DW=14, AW=5 and SW=4. That gives 31 nodes and 16 stack frames. At this size a perfectly balanced tree can fill node memory completely, so the capacity stop can be reached. A 20-item ascending chain can overflow the stack after exactly 17 emitted items. The same configuration still holds the 21-item example sequence together with a second portion, and expected orders are computed in the bench by sorting its own list of accepted items.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WALK  = 3'd1,
    ST_ENTER = 3'd2,
    ST_EMIT  = 3'd3,
    ST_RET   = 3'd4
  } state_e;

  // Return code saved with each stack frame: which branch the call came from.
  typedef enum logic {
    RC_LEFT  = 1'b0,
    RC_RIGHT = 1'b1
  } ret_e;
endpackage

// File: rtl/bst_node_ram.sv
module bst_node_ram #(
  parameter int DW = 14,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          new_en,
  input  logic [AW-1:0] new_addr,
  input  logic [DW-1:0] new_val,
  input  logic          link_en,
  input  logic          link_right,
  input  logic [AW-1:0] link_addr,
  input  logic [AW-1:0] link_ptr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_val,
  output logic [AW-1:0] rd_left,
  output logic [AW-1:0] rd_right
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] val_m   [DEPTH];
  logic [AW-1:0] left_m  [DEPTH];
  logic [AW-1:0] right_m [DEPTH];

  assign rd_val   = val_m[rd_addr];
  assign rd_left  = left_m[rd_addr];
  assign rd_right = right_m[rd_addr];

  always_ff @(posedge clk) begin
    if (new_en) begin
      val_m[new_addr]   <= new_val;
      left_m[new_addr]  <= '0;
      right_m[new_addr] <= '0;
    end
    if (link_en) begin
      if (link_right) right_m[link_addr] <= link_ptr;
      else            left_m[link_addr]  <= link_ptr;
    end
  end

  // R2: a fresh leaf never shares its address with the parent being linked
  a_r2_distinct_write: assert property (@(posedge clk)
    (new_en && link_en) |-> (new_addr != link_addr));
endmodule

// File: rtl/bst_stack.sv
module bst_stack #(
  parameter int AW = 10,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  input  logic          push_rc,
  output logic [AW-1:0] top_addr,
  output logic          top_rc,
  output logic          empty,
  output logic          full
);
  localparam int DEPTH = 1 << SW;

  logic [AW:0]   mem [DEPTH];
  logic [SW:0]   sp;
  logic [SW-1:0] top_idx;

  assign empty   = (sp == '0);
  assign full    = (sp == (SW+1)'(DEPTH));
  assign top_idx = SW'(sp - 1'b1);
  assign top_addr = mem[top_idx][AW:1];
  assign top_rc   = mem[top_idx][0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sp <= '0;
    end else if (push) begin
      mem[sp[SW-1:0]] <= {push_addr, push_rc};
      sp <= sp + 1'b1;
    end else if (pop) begin
      sp <= sp - 1'b1;
    end
  end

  a_r9_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r9_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/bst_sorter.sv
module bst_sorter #(
  parameter int DW = 14,
  parameter int AW = 10,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          start_rd,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          busy,
  output logic          stk_err
);
  import bst_pkg::*;

  localparam int CAP = (1 << AW) - 1;
  localparam logic [AW-1:0] ROOT = AW'(1);

  function automatic logic goes_left(input logic [DW-1:0] item_v,
                                     input logic [DW-1:0] node_v);
    return item_v < node_v;   // equal values take the right branch
  endfunction

  function automatic logic at_capacity(input logic [AW-1:0] n);
    return n == AW'(CAP);
  endfunction

  state_e        st;
  logic [AW-1:0] cur, cnt, emit_cnt;
  logic [DW-1:0] item, last_q;
  logic          err_q, have_q;

  logic [DW-1:0] nd_val;
  logic [AW-1:0] nd_l, nd_r, child;
  logic          go_left;

  logic          stk_push, stk_pop, stk_empty, stk_full, top_rc_bit;
  logic [AW-1:0] top_addr;
  logic          want_push_l, want_push_r, want_push, push_rc;

  logic          new_en;
  logic [AW-1:0] new_addr;
  logic [DW-1:0] new_val;

  // Named internal events
  logic ev_accept, ev_start, ev_place, ev_overflow;

  assign go_left  = goes_left(item, nd_val);
  assign child    = go_left ? nd_l : nd_r;

  assign in_ready = (st == ST_IDLE) && !start_rd && !at_capacity(cnt);
  assign ev_accept = in_valid && in_ready;
  assign ev_start  = (st == ST_IDLE) && start_rd && (cnt != '0);
  assign ev_place  = (st == ST_WALK) && (child == '0);

  assign want_push_l = (st == ST_ENTER) && (nd_l != '0);
  assign want_push_r = (st == ST_EMIT)  && (nd_r != '0);
  assign want_push   = want_push_l || want_push_r;
  assign push_rc     = want_push_r ? RC_RIGHT : RC_LEFT;
  assign ev_overflow = want_push && stk_full;
  assign stk_push    = want_push && !stk_full;
  assign stk_pop     = (st == ST_RET) && !stk_empty;

  assign new_en   = (ev_accept && (cnt == '0)) || ev_place;
  assign new_addr = cnt + AW'(1);
  assign new_val  = (st == ST_IDLE) ? in_data : item;

  assign out_valid = (st == ST_EMIT);
  assign out_data  = nd_val;
  assign out_last  = out_valid && (emit_cnt == cnt - AW'(1));
  assign busy      = (st != ST_IDLE);
  assign stk_err   = err_q;

  bst_node_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk        (clk),
    .new_en     (new_en),
    .new_addr   (new_addr),
    .new_val    (new_val),
    .link_en    (ev_place),
    .link_right (!go_left),
    .link_addr  (cur),
    .link_ptr   (new_addr),
    .rd_addr    (cur),
    .rd_val     (nd_val),
    .rd_left    (nd_l),
    .rd_right   (nd_r)
  );

  bst_stack #(.AW(AW), .SW(SW)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ev_start),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_addr (cur),
    .push_rc   (push_rc),
    .top_addr  (top_addr),
    .top_rc    (top_rc_bit),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur      <= '0;
      cnt      <= '0;
      emit_cnt <= '0;
      item     <= '0;
      err_q    <= 1'b0;
      have_q   <= 1'b0;
      last_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ev_start) begin
            cur      <= ROOT;
            emit_cnt <= '0;
            have_q   <= 1'b0;
            st       <= ST_ENTER;
          end else if (ev_accept) begin
            if (cnt == '0) begin
              cnt <= AW'(1);
            end else begin
              item <= in_data;
              cur  <= ROOT;
              st   <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (ev_place) begin
            cnt <= cnt + AW'(1);
            st  <= ST_IDLE;
          end else begin
            cur <= child;
          end
        end
        ST_ENTER: begin
          if (ev_overflow) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else if (want_push_l) begin
            cur <= nd_l;
          end else begin
            st <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          emit_cnt <= emit_cnt + AW'(1);
          have_q   <= 1'b1;
          last_q   <= nd_val;
          if (ev_overflow) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else if (want_push_r) begin
            cur <= nd_r;
            st  <= ST_ENTER;
          end else begin
            st <= ST_RET;
          end
        end
        ST_RET: begin
          if (stk_empty) begin
            st <= ST_IDLE;
          end else begin
            cur <= top_addr;
            st  <= (ret_e'(top_rc_bit) == RC_LEFT) ? ST_EMIT : ST_RET;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && have_q) |-> (out_data >= last_q));
  a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == AW'(CAP)) |-> !in_ready);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);
  a_r10_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |-> !in_ready);
endmodule

// File: tb/tb_bst_sorter.sv
`timescale 1ns/1ps
module tb_bst_sorter;
  localparam int DW = 14;
  localparam int AW = 5;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready;
  logic start_rd = 1'b0;
  logic out_valid, out_last, busy, stk_err;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  bst_sorter #(.DW(DW), .AW(AW), .SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .start_rd(start_rd), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .busy(busy), .stk_err(stk_err)
  );

  int ntot = 0;
  int nbad = 0;
  int model [64];
  int nmod = 0;
  int got [64];
  bit gotlast [64];
  int ngot = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; start_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nmod = 0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
  endtask

  task automatic put(input int v);
    int g;
    in_valid = 1'b1;
    in_data  = DW'(v);
    g = 0;
    while (!in_ready && g < 2000) begin @(negedge clk); g++; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    model[nmod] = v;
    nmod++;
  endtask

  task automatic collect();
    ngot = 0;
    for (int g = 0; g < 4000 && busy; g++) begin
      if (out_valid) begin
        got[ngot] = int'(out_data);
        gotlast[ngot] = out_last;
        ngot++;
      end
      @(negedge clk);
    end
  endtask

  task automatic readout();
    start_rd = 1'b1;
    @(negedge clk);
    start_rd = 1'b0;
    collect();
  endtask

  // Compare emitted items against the bench's own sorted copy of accepted items.
  task automatic check_out(input string tag, input int expn, input bit expect_last);
    int s [64];
    int t, nl;
    for (int i = 0; i < nmod; i++) s[i] = model[i];
    for (int i = 0; i < nmod; i++)
      for (int j = 0; j + 1 < nmod - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    chk(ngot == expn, {tag, " count"}, ngot, expn);
    for (int i = 0; i < ngot && i < expn; i++)
      chk(got[i] == s[i], {tag, " order"}, got[i], s[i]);
    nl = 0;
    for (int i = 0; i < ngot; i++) if (gotlast[i]) nl++;
    chk(nl == (expect_last ? 1 : 0), "R4 last count", nl, expect_last ? 1 : 0);
    if (expect_last && ngot > 0)
      chk(gotlast[ngot-1] == 1'b1, "R4 last position", gotlast[ngot-1], 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nbad++; ntot++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
      end
    end
  end

  initial begin
    int doc [21];
    int x;
    int v;
    doc = '{24, 17, 35, 30, 8, 61, 12, 18, 1, 25, 10, 15, 19, 20, 21, 40, 9, 7, 11, 16, 50};

    // R1: reset state
    do_reset();
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(out_last == 1'b0, "R1 out_last", out_last, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(stk_err == 1'b0, "R1 stk_err", stk_err, 0);

    // R6: readout request on an empty tree does nothing
    begin
      int seen;
      seen = 0;
      start_rd = 1'b1;
      @(negedge clk);
      start_rd = 1'b0;
      for (int i = 0; i < 20; i++) begin
        if (out_valid || busy) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R6 empty start ignored", seen, 0);
    end

    // R2/R5: example sequence, then ascending readout
    for (int i = 0; i < 21; i++) begin
      put(doc[i]);
      if (i == 1) begin
        chk(busy == 1'b1, "R5 busy during walk", busy, 1);
        chk(in_ready == 1'b0, "R5 ready low during walk", in_ready, 0);
      end
      wait_idle();
    end
    readout();
    check_out("R2 example", 21, 1'b1);

    // R7: second portion merged into the existing tree
    x = 7;
    for (int i = 0; i < 7; i++) begin
      x = (x * 1103515245 + 12345) & 32'h7fffffff;
      put((x >> 8) & 16'h3fff);
      wait_idle();
    end
    readout();
    check_out("R7 second portion", 28, 1'b1);
    readout();
    check_out("R7 repeat readout", 28, 1'b1);

    // R3: duplicates are kept
    do_reset();
    put(5); wait_idle(); put(5); wait_idle(); put(3); wait_idle();
    put(5); wait_idle(); put(7); wait_idle(); put(3); wait_idle();
    readout();
    check_out("R3 duplicates", 6, 1'b1);

    // R10: start_rd wins over a waiting input item
    do_reset();
    put(10); wait_idle(); put(20); wait_idle(); put(30); wait_idle();
    in_valid = 1'b1; in_data = DW'(5); start_rd = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R10 ready low with start_rd", in_ready, 0);
    @(negedge clk);
    start_rd = 1'b0; in_valid = 1'b0;
    collect();
    check_out("R10 item not taken", 3, 1'b1);

    // R8: fill all 31 nodes with a balanced order, then further input is held off
    do_reset();
    for (int tz = 4; tz >= 0; tz--)
      for (int k = 0; ((2*k+1) << tz) < 32; k++) begin
        put((2*k+1) << tz);
        wait_idle();
      end
    chk(nmod == 31, "R8 items inserted", nmod, 31);
    chk(in_ready == 1'b0, "R8 ready low at capacity", in_ready, 0);
    in_valid = 1'b1; in_data = DW'(99);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (in_ready) hi++;
      end
      chk(hi == 0, "R8 ready stays low", hi, 0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    readout();
    check_out("R8 full readout", 31, 1'b1);

    // R9: ascending chain deeper than the stack
    do_reset();
    for (int i = 1; i <= 20; i++) begin
      put(i);
      wait_idle();
    end
    readout();
    v = (1 << SW) + 1;
    check_out("R9 overflow", v, 1'b0);
    chk(stk_err == 1'b1, "R9 error flag set", stk_err, 1);
    chk(busy == 1'b0, "R9 readout ended", busy, 0);
    repeat (5) @(negedge clk);
    chk(stk_err == 1'b1, "R9 error flag sticky", stk_err, 1);

    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule